// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This block applies the SHA-256 compression function to a single 512-bit message block. A caller presents the block as sixteen big-endian 32-bit words together with a 256-bit chaining state and a first-block flag, then pulses a start strobe. The engine takes a snapshot of all of these at the start edge. It then runs one round per clock for 64 clocks and raises a done flag with the updated 256-bit hash on its output.

The message schedule is expanded in place. A 16-word rolling window holds the next sixteen schedule words, and each word from round 16 onward is computed from four earlier window entries and overwrites the oldest one. The 64 round constants come from a combinational table that the round counter addresses. Padding the message, assembling bytes into words and sequencing several blocks belong to the caller. To chain blocks, the caller feeds each result back as the chaining state with the first-block flag low.

Top module: `sha256_block_engine`

## Requirements
- R1: A start pulse accepted while idle runs exactly 64 rounds, one per clock. `done_o` is low after the edge that samples the start and rises after the 64th rising edge that follows that edge.
- R2: Schedule word t is input word t for t below 16. For t of 16 and above it is σ1(W[t-2]) + W[t-7] + σ0(W[t-15]) + W[t-16] mod 2^32, held in a 16-word window indexed by t mod 16.
- R3: With `first_i` high at the start edge, the working variables start from the standard SHA-256 initial hash values and `prev_i` has no effect on the result.
- R4: With `first_i` low at the start edge, the working variables start from `prev_i`, so chaining blocks yields the multi-block digest.
- R5: The result is the starting state plus the final working variables, word by word mod 2^32. It is valid whenever `done_o` is high.
- R6: Word 0 of the block sits in `block_i[511:480]`, word 15 in `block_i[31:0]`. Hash word A sits in bits [255:224] of both `prev_i` and `hash_o`.
- R7: The block, chaining state and flag are captured at the start edge. Changing them while rounds run does not alter the result.
- R8: A start pulse while rounds are running is ignored: the round counter keeps advancing and the result and its timing are those of the first start.
- R9: `done_o` and `hash_o` hold until the next accepted start. `done_o` falls after the edge that accepts that start.
- R10: A synchronous active-high reset clears the round counter, returns the engine to idle with `done_o` low, and abandons any block in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for one block |
| first_i | input | 1 | High: start from initial hash values; low: start from prev_i |
| block_i | input | 512 | Message block, word 0 in the top 32 bits |
| prev_i | input | 256 | Chaining state, word A in the top 32 bits |
| hash_o | output | 256 | Updated hash, word A in the top 32 bits |
| done_o | output | 1 | Result valid; held until the next accepted start |

## Verification
The result is due 64 cycles after the edge that samples the start. The bench drives inputs on falling edges and counts falling edges from the start edge, so `done_o` must first be seen on the 65th falling edge and never earlier. Digests are checked against published SHA-256 vectors at that sample point, and hold behaviour is checked on the falling edges that follow. Ignored starts and input changes mid-block are checked by confirming that the first block's digest still arrives on the same falling edge.

// File: rtl/sha_core_pkg.sv
package sha_core_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 8;
    localparam int ROUNDS    = 64;
    localparam int WIN_DEPTH = 16;
    localparam int RND_W     = $clog2(ROUNDS);
    localparam int WIN_W     = $clog2(WIN_DEPTH);
    localparam int BLOCK_W   = WORD_W * WIN_DEPTH;
    localparam int STATE_W   = WORD_W * NUM_WORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RND_W-1:0]  rnd_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } state_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    localparam state_t INIT_STATE = '{
        a: 32'h6a09e667, b: 32'hbb67ae85, c: 32'h3c6ef372, d: 32'ha54ff53a,
        e: 32'h510e527f, f: 32'h9b05688c, g: 32'h1f83d9ab, h: 32'h5be0cd19
    };

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t sml_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sml_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t majority(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic state_t round_step(input state_t s, input word_t k, input word_t w);
        state_t n;
        word_t  t1;
        word_t  t2;
        t1 = s.h + big_sig1(s.e) + choose(s.e, s.f, s.g) + k + w;
        t2 = big_sig0(s.a) + majority(s.a, s.b, s.c);
        n.a = t1 + t2;
        n.b = s.a;
        n.c = s.b;
        n.d = s.c;
        n.e = s.d + t1;
        n.f = s.e;
        n.g = s.f;
        n.h = s.g;
        return n;
    endfunction

    function automatic state_t state_sum(input state_t x, input state_t y);
        state_t r;
        r.a = x.a + y.a;
        r.b = x.b + y.b;
        r.c = x.c + y.c;
        r.d = x.d + y.d;
        r.e = x.e + y.e;
        r.f = x.f + y.f;
        r.g = x.g + y.g;
        r.h = x.h + y.h;
        return r;
    endfunction

endpackage

// File: rtl/sha_round_const.sv
module sha_round_const
    import sha_core_pkg::*;
(
    input  rnd_t  idx_i,
    output word_t k_o
);

    always_comb begin
        case (idx_i)
            6'd0:  k_o = 32'h428a2f98;  6'd1:  k_o = 32'h71374491;
            6'd2:  k_o = 32'hb5c0fbcf;  6'd3:  k_o = 32'he9b5dba5;
            6'd4:  k_o = 32'h3956c25b;  6'd5:  k_o = 32'h59f111f1;
            6'd6:  k_o = 32'h923f82a4;  6'd7:  k_o = 32'hab1c5ed5;
            6'd8:  k_o = 32'hd807aa98;  6'd9:  k_o = 32'h12835b01;
            6'd10: k_o = 32'h243185be;  6'd11: k_o = 32'h550c7dc3;
            6'd12: k_o = 32'h72be5d74;  6'd13: k_o = 32'h80deb1fe;
            6'd14: k_o = 32'h9bdc06a7;  6'd15: k_o = 32'hc19bf174;
            6'd16: k_o = 32'he49b69c1;  6'd17: k_o = 32'hefbe4786;
            6'd18: k_o = 32'h0fc19dc6;  6'd19: k_o = 32'h240ca1cc;
            6'd20: k_o = 32'h2de92c6f;  6'd21: k_o = 32'h4a7484aa;
            6'd22: k_o = 32'h5cb0a9dc;  6'd23: k_o = 32'h76f988da;
            6'd24: k_o = 32'h983e5152;  6'd25: k_o = 32'ha831c66d;
            6'd26: k_o = 32'hb00327c8;  6'd27: k_o = 32'hbf597fc7;
            6'd28: k_o = 32'hc6e00bf3;  6'd29: k_o = 32'hd5a79147;
            6'd30: k_o = 32'h06ca6351;  6'd31: k_o = 32'h14292967;
            6'd32: k_o = 32'h27b70a85;  6'd33: k_o = 32'h2e1b2138;
            6'd34: k_o = 32'h4d2c6dfc;  6'd35: k_o = 32'h53380d13;
            6'd36: k_o = 32'h650a7354;  6'd37: k_o = 32'h766a0abb;
            6'd38: k_o = 32'h81c2c92e;  6'd39: k_o = 32'h92722c85;
            6'd40: k_o = 32'ha2bfe8a1;  6'd41: k_o = 32'ha81a664b;
            6'd42: k_o = 32'hc24b8b70;  6'd43: k_o = 32'hc76c51a3;
            6'd44: k_o = 32'hd192e819;  6'd45: k_o = 32'hd6990624;
            6'd46: k_o = 32'hf40e3585;  6'd47: k_o = 32'h106aa070;
            6'd48: k_o = 32'h19a4c116;  6'd49: k_o = 32'h1e376c08;
            6'd50: k_o = 32'h2748774c;  6'd51: k_o = 32'h34b0bcb5;
            6'd52: k_o = 32'h391c0cb3;  6'd53: k_o = 32'h4ed8aa4a;
            6'd54: k_o = 32'h5b9cca4f;  6'd55: k_o = 32'h682e6ff3;
            6'd56: k_o = 32'h748f82ee;  6'd57: k_o = 32'h78a5636f;
            6'd58: k_o = 32'h84c87814;  6'd59: k_o = 32'h8cc70208;
            6'd60: k_o = 32'h90befffa;  6'd61: k_o = 32'ha4506ceb;
            6'd62: k_o = 32'hbef9a3f7;  default: k_o = 32'hc67178f2;
        endcase
    end

endmodule

// File: rtl/sha_sched_window.sv
module sha_sched_window
    import sha_core_pkg::*;
(
    input  logic               clk,
    input  logic               load_i,
    input  logic               adv_i,
    input  rnd_t               round_i,
    input  logic [BLOCK_W-1:0] block_i,
    output word_t              wt_o
);

    word_t             win_q [WIN_DEPTH];
    logic [WIN_W-1:0]  slot;
    word_t             expanded;
    logic              use_expanded;

    // Slot t mod 16 holds W[t-16] before it is replaced by W[t].
    assign slot         = round_i[WIN_W-1:0];
    assign use_expanded = (round_i >= rnd_t'(WIN_DEPTH));
    assign expanded     = sml_sig1(win_q[slot - WIN_W'(2)])
                        + win_q[slot - WIN_W'(7)]
                        + sml_sig0(win_q[slot - WIN_W'(15)])
                        + win_q[slot];
    assign wt_o         = use_expanded ? expanded : win_q[slot];

    generate
        for (genvar i = 0; i < WIN_DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (load_i) begin
                    win_q[i] <= block_i[BLOCK_W-1-WORD_W*i -: WORD_W];
                end else if (adv_i && use_expanded && (slot == WIN_W'(i))) begin
                    win_q[i] <= expanded;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sha256_block_engine.sv
module sha256_block_engine
    import sha_core_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         first_i,
    input  logic [511:0] block_i,
    input  logic [255:0] prev_i,
    output logic [255:0] hash_o,
    output logic         done_o
);

    eng_state_e state_q;
    rnd_t       round_q;
    state_t     work_q;
    state_t     base_q;
    state_t     work_next;
    state_t     hash_q;
    state_t     init_state;
    word_t      k_cur;
    word_t      w_cur;
    logic       busy;
    logic       accept;
    logic       last_round;

    assign busy       = (state_q == ENG_RUN);
    assign accept     = start_i && !busy;
    assign last_round = (round_q == rnd_t'(ROUNDS - 1));
    assign init_state = first_i ? INIT_STATE : state_t'(prev_i);

    sha_round_const u_kconst (
        .idx_i (round_q),
        .k_o   (k_cur)
    );

    sha_sched_window u_window (
        .clk     (clk),
        .load_i  (accept),
        .adv_i   (busy),
        .round_i (round_q),
        .block_i (block_i),
        .wt_o    (w_cur)
    );

    assign work_next = round_step(work_q, k_cur, w_cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            round_q <= '0;
            done_o  <= 1'b0;
        end else if (accept) begin
            state_q <= ENG_RUN;
            round_q <= '0;
            done_o  <= 1'b0;
        end else if (busy) begin
            round_q <= round_q + rnd_t'(1);
            if (last_round) begin
                state_q <= ENG_IDLE;
                done_o  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            base_q <= '0;
            hash_q <= '0;
        end else if (accept) begin
            work_q <= init_state;
            base_q <= init_state;
        end else if (busy) begin
            work_q <= work_next;
            if (last_round) begin
                hash_q <= state_sum(base_q, work_next);
            end
        end
    end

    assign hash_o = hash_q;

endmodule

// File: rtl/sha_engine_checker.sv
module sha_engine_checker
    import sha_core_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         done_o,
    input logic [255:0] hash_o,
    input logic         busy,
    input rnd_t         round_q
);

    logic       act_q;
    logic [6:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i && !busy) begin
            act_q <= 1'b1;
            cnt_q <= '0;
        end else if (act_q) begin
            if (cnt_q == 7'(ROUNDS)) act_q <= 1'b0;
            else                     cnt_q <= cnt_q + 7'd1;
        end
    end

    AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (rst)
        act_q && cnt_q == 7'(ROUNDS) |-> done_o); // R1

    AST_DONE_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        act_q && cnt_q < 7'(ROUNDS) |-> !done_o); // R1

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done_o && busy)); // R1

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy && start_i && round_q != rnd_t'(ROUNDS - 1)
        |=> busy && round_q == $past(round_q) + rnd_t'(1)); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        done_o && !start_i |=> done_o && $stable(hash_o)); // R9

endmodule

bind sha256_block_engine sha_engine_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .done_o  (done_o),
    .hash_o  (hash_o),
    .busy    (busy),
    .round_q (round_q)
);

// File: tb/sha256_block_engine_test.sv
module sha256_block_engine_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         first = 1'b1;
    logic [511:0] block = '0;
    logic [255:0] prev = '0;
    logic [255:0] hash;
    logic         done;

    int checks = 0;
    int errors = 0;

    localparam logic [511:0] BLK_ABC = {32'h61626380, {14{32'h0}}, 32'h00000018};
    localparam logic [511:0] BLK_EMPTY = {32'h80000000, {15{32'h0}}};
    localparam logic [511:0] BLK_TWO_A = {
        32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
        32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
        32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
        32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
    localparam logic [511:0] BLK_TWO_B = {{15{32'h0}}, 32'h000001c0};
    localparam logic [255:0] DG_ABC =
        256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad;
    localparam logic [255:0] DG_EMPTY =
        256'he3b0c442_98fc1c14_9afbf4c8_996fb924_27ae41e4_649b934c_a495991b_7852b855;
    localparam logic [255:0] DG_TWO =
        256'h248d6a61_d20638b8_e5c02693_0c3e6039_a33ce459_64ff2167_f6ecedd4_19db06c1;
    localparam int DONE_EDGE = 65;

    always #4 clk = ~clk;

    sha256_block_engine uut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .first_i (first),
        .block_i (block),
        .prev_i  (prev),
        .hash_o  (hash),
        .done_o  (done)
    );

    task automatic check_val(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic kick(input logic [511:0] blk, input logic [255:0] pv, input logic fst);
        @(negedge clk);
        block = blk; prev = pv; first = fst; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Called on the first falling edge after the start edge; returns its count.
    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset_state();
        check_val("R10 done low after reset", 256'(done), 256'(0));
    endtask

    task automatic t_single(input string tag, input logic [511:0] blk, input logic [255:0] dg);
        int lat;
        kick(blk, 256'hdead_beef, 1'b1);
        wait_done(lat);
        check_val({tag, " R1 latency"}, 256'(lat), 256'(DONE_EDGE));
        check_val({tag, " R2 R5 R6 digest"}, hash, dg);
    endtask

    task automatic t_iv_ignores_prev();
        int lat;
        kick(BLK_ABC, {8{32'h5a5a_a5a5}}, 1'b1);
        wait_done(lat);
        check_val("R3 prev ignored when first high", hash, DG_ABC);
    endtask

    task automatic t_chain();
        int lat;
        logic [255:0] mid;
        kick(BLK_TWO_A, 256'h0, 1'b1);
        wait_done(lat);
        mid = hash;
        kick(BLK_TWO_B, mid, 1'b0);
        wait_done(lat);
        check_val("R4 chained digest", hash, DG_TWO);
        check_val("R4 chained latency", 256'(lat), 256'(DONE_EDGE));
    endtask

    task automatic t_hold();
        int lat;
        logic [255:0] held;
        kick(BLK_EMPTY, 256'h0, 1'b1);
        wait_done(lat);
        held = hash;
        repeat (7) @(negedge clk);
        block = BLK_ABC; first = 1'b0;
        repeat (3) @(negedge clk);
        check_val("R9 done held", 256'(done), 256'(1));
        check_val("R9 hash held", hash, held);
        kick(BLK_ABC, 256'h0, 1'b1);
        check_val("R9 done falls after accepted start", 256'(done), 256'(0));
        wait_done(lat);
        check_val("R9 next result", hash, DG_ABC);
    endtask

    task automatic t_busy_start_and_inputs();
        int lat;
        kick(BLK_ABC, 256'h0, 1'b1);
        lat = 1;
        while (!done && lat < 200) begin
            if (lat == 10) begin
                start = 1'b1; block = BLK_EMPTY; first = 1'b0; prev = {8{32'h1234_5678}};
            end else if (lat == 11) begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        check_val("R8 ignored start keeps timing", 256'(lat), 256'(DONE_EDGE));
        check_val("R7 R8 result of first start", hash, DG_ABC);
    endtask

    task automatic t_reset_abort();
        kick(BLK_EMPTY, 256'h0, 1'b1);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_val("R10 done low after mid-block reset", 256'(done), 256'(0));
        repeat (70) @(negedge clk);
        check_val("R10 aborted block never completes", 256'(done), 256'(0));
        t_single("R10 restart", BLK_ABC, DG_ABC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_single("abc", BLK_ABC, DG_ABC);
        t_single("empty", BLK_EMPTY, DG_EMPTY);
        t_iv_ignores_prev();
        t_chain();
        t_hold();
        t_busy_start_and_inputs();
        t_reset_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule